// File: doc/BRIEF.md
# Vector byte multiply-sum accumulate unit

This execution unit carries out one vector instruction on 128-bit operands. It multiplies unsigned byte lanes of two sources pairwise and adds each adjacent pair of products into a 32-bit word. It then adds the matching 32-bit word of a third, accumulator source. Each word result wraps modulo 2^32, and the unit raises no flags.

A 32-bit instruction word arrives with the three operands over a valid/ready handshake. The unit checks the instruction's two opcode fields and passes the destination register index through with the result. A vector-enable input gates execution. When the enable is low, a matching instruction produces an unavailable exception instead of a result.

The result register holds its value under downstream backpressure. The register file, hazard handling and exception vectoring sit outside the unit.

Top module: `vmsum_unit`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after reset, `out_valid` and `out_exc` are low.
- R2: Numbering is big-endian. Byte j of a vector is bits [127-8j -: 8] and word k is bits [127-32k -: 32]. Word k of `out_data` equals A.byte(2k)·B.byte(2k) + A.byte(2k+1)·B.byte(2k+1) + C.word(k), with every byte unsigned.
- R3: Each word result is reduced modulo 2^32, and carries out of a word are dropped. All-0xFF bytes in A and B with an all-ones accumulator word give 0x0001FC01.
- R4: Bytes 8 to 15 of A and B have no effect on the result.
- R5: An instruction matches when `in_insn[31:26]` equals 4 and `in_insn[5:0]` equals 36. On a result, `out_dest` equals `in_insn[25:21]` of the accepted instruction.
- R6: An accepted instruction that does not match raises neither `out_valid` nor `out_exc` on the next cycle.
- R7: An accepted matching instruction with `vec_en` low raises `out_exc` for exactly the next cycle, and `out_valid` stays low.
- R8: An accepted matching instruction with `vec_en` high gives `out_valid` high on the next cycle, with the result.
- R9: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_data` and `out_dest` keep their values.
- R10: `in_ready` is high exactly when `out_valid` is low or `out_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| vec_en | input | 1 | Vector facility enable |
| in_valid | input | 1 | Instruction and operands are offered |
| in_ready | output | 1 | Unit accepts the offer this cycle |
| in_insn | input | 32 | Instruction word |
| in_a | input | 128 | First multiplicand vector |
| in_b | input | 128 | Second multiplicand vector |
| in_c | input | 128 | Accumulator vector |
| out_valid | output | 1 | Result is present |
| out_ready | input | 1 | Downstream takes the result |
| out_data | output | 128 | Four 32-bit word results |
| out_dest | output | 5 | Destination register index |
| out_exc | output | 1 | Vector-unavailable exception pulse |

## Verification
The bench builds the unit with its default parameters: 8-bit lanes, 32-bit words, four words per vector and opcodes 4 and 36. At that width the all-0xFF products and an all-ones accumulator reach the modulo-2^32 wrap in every word, and the whole 32-bit opcode space can be driven. A behavioural model tracks the handshake and the expected result on every cycle. It is compared against the outputs under random backpressure, on mismatched opcodes, with the enable low, and with only the upper eight bytes changed.

// File: rtl/vmsum_unit.sv
module vmsum_unit #(
  parameter int LANE_W  = 8,
  parameter int WORD_W  = 32,
  parameter int WORDS   = 4,
  parameter int INSN_W  = 32,
  parameter int REG_W   = 5,
  parameter int PRI_OP  = 4,
  parameter int EXT_OP  = 36
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      vec_en,
  input  logic                      in_valid,
  output logic                      in_ready,
  input  logic [INSN_W-1:0]         in_insn,
  input  logic [WORDS*WORD_W-1:0]   in_a,
  input  logic [WORDS*WORD_W-1:0]   in_b,
  input  logic [WORDS*WORD_W-1:0]   in_c,
  output logic                      out_valid,
  input  logic                      out_ready,
  output logic [WORDS*WORD_W-1:0]   out_data,
  output logic [REG_W-1:0]          out_dest,
  output logic                      out_exc
);
  localparam int VEC_W   = WORDS * WORD_W;
  localparam int PRI_W   = 6;
  localparam int EXT_W   = 6;
  localparam int PROD_W  = 2 * LANE_W;
  localparam int DEST_LO = INSN_W - PRI_W - REG_W;
  localparam int SRC_HI  = DEST_LO - 1;

  logic accept, match, do_exec, do_exc;
  logic [VEC_W-1:0] sum_vec;

  assign match   = (in_insn[INSN_W-1 -: PRI_W] == PRI_W'(PRI_OP)) &&
                   (in_insn[EXT_W-1:0] == EXT_W'(EXT_OP));
  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;
  assign do_exec  = accept && match && vec_en;
  assign do_exc   = accept && match && !vec_en;

  wire unused_src = ^{in_insn[SRC_HI:EXT_W], in_a[VEC_W/2-1:0], in_b[VEC_W/2-1:0]};

  for (genvar k = 0; k < WORDS; k++) begin : g_word
    localparam int HI_E = VEC_W - 1 - 2 * k * LANE_W;
    localparam int HI_O = HI_E - LANE_W;
    localparam int HI_W = VEC_W - 1 - k * WORD_W;
    logic [PROD_W-1:0] p_even, p_odd;
    assign p_even = in_a[HI_E -: LANE_W] * in_b[HI_E -: LANE_W];
    assign p_odd  = in_a[HI_O -: LANE_W] * in_b[HI_O -: LANE_W];
    assign sum_vec[HI_W -: WORD_W] = in_c[HI_W -: WORD_W] + WORD_W'(p_even) + WORD_W'(p_odd);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_exc   <= 1'b0;
      out_data  <= '0;
      out_dest  <= '0;
    end else begin
      out_exc <= do_exc;
      if (accept) begin
        out_valid <= do_exec;
        if (do_exec) begin
          out_data <= sum_vec;
          out_dest <= in_insn[INSN_W-PRI_W-1 -: REG_W];
        end
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_dest));
  p_exec_r8: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && match && vec_en |=> out_valid && !out_exc);
  p_dest_r5: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && match && vec_en |=> out_dest == $past(in_insn[INSN_W-PRI_W-1 -: REG_W]));
  p_nomatch_r6: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && !match |=> !out_valid && !out_exc);
  p_unavail_r7: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && match && !vec_en |=> out_exc && !out_valid);
  p_exc_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_valid && in_ready) |=> !out_exc);
endmodule

// File: tb/test_vmsum_unit.sv
module test_vmsum_unit;
  logic clk = 0, rst_n = 0, vec_en = 1, in_valid = 0, out_ready = 1;
  logic in_ready, out_valid, out_exc;
  logic [31:0] in_insn = '0;
  logic [127:0] in_a = '0, in_b = '0, in_c = '0, out_data;
  logic [4:0] out_dest;

  vmsum_unit i_vmsum_unit (.clk, .rst_n, .vec_en, .in_valid, .in_ready, .in_insn,
    .in_a, .in_b, .in_c, .out_valid, .out_ready, .out_data, .out_dest, .out_exc);

  always #2 clk = ~clk;

  int checks = 0, fails = 0, cycles = 0;
  bit done = 0, bp_mode = 0;
  string phase = "R1";

  logic m_valid = 0, m_exc = 0;
  logic [127:0] m_data = '0;
  logic [4:0] m_dest = '0;

  function automatic logic [127:0] ref_calc(logic [127:0] a, logic [127:0] b, logic [127:0] c);
    logic [127:0] r;
    for (int k = 0; k < 4; k++) begin
      longint unsigned s;
      s = c[127 - 32*k -: 32];
      for (int j = 2*k; j < 2*k + 2; j++)
        s += longint'(a[127 - 8*j -: 8]) * longint'(b[127 - 8*j -: 8]);
      r[127 - 32*k -: 32] = s[31:0];
    end
    return r;
  endfunction

  function automatic bit is_match(logic [31:0] w);
    return (w[31:26] == 6'd4) && (w[5:0] == 6'd36);
  endfunction

  always @(posedge clk) begin
    cycles++;
    if (!rst_n) begin
      m_valid = 0; m_exc = 0;
    end else begin
      bit acc;
      acc = in_valid && (!m_valid || out_ready);
      m_exc = acc && is_match(in_insn) && !vec_en;
      if (acc) begin
        m_valid = is_match(in_insn) && vec_en;
        if (m_valid) begin
          m_data = ref_calc(in_a, in_b, in_c);
          m_dest = in_insn[25:21];
        end
      end else if (out_ready) m_valid = 0;
    end
  end

  task automatic cmp(string tag, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s at cycle %0d: actual %h expected %h", tag, cycles, act, exp);
    end
  endtask

  always @(negedge clk) if (!done) begin
    cmp({phase, " out_valid"}, 128'(out_valid), 128'(m_valid));
    cmp({phase, " out_exc"}, 128'(out_exc), 128'(m_exc));
    if (rst_n) cmp("R10 in_ready", 128'(in_ready), 128'(!m_valid || out_ready));
    if (m_valid) begin
      cmp({phase, " out_data"}, out_data, m_data);
      cmp({phase, " R5 out_dest"}, 128'(out_dest), 128'(m_dest));
    end
  end

  always @(posedge clk) if (bp_mode) begin
    #1 out_ready = ($urandom % 3) != 0;
  end

  function automatic logic [127:0] rvec();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  function automatic logic [31:0] good_insn();
    logic [31:0] w;
    w = $urandom;
    w[31:26] = 6'd4;
    w[5:0] = 6'd36;
    return w;
  endfunction

  task automatic send(logic [31:0] w, logic [127:0] a, logic [127:0] b, logic [127:0] c, logic en);
    logic r;
    @(posedge clk); #1;
    in_valid = 1; in_insn = w; in_a = a; in_b = b; in_c = c; vec_en = en;
    do begin
      @(negedge clk); r = in_ready;
      @(posedge clk);
    end while (!r);
    #1 in_valid = 0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  endtask

  initial begin
    forever begin
      @(posedge clk);
      if (cycles > 100000) begin
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
      end
    end
  end

  initial begin
    logic [127:0] a, b;
    phase = "R1";
    repeat (4) @(posedge clk);
    #1 rst_n = 1;
    repeat (2) @(posedge clk);

    phase = "R2";
    for (int i = 0; i < 40; i++) send(good_insn(), rvec(), rvec(), rvec(), 1);
    send(32'h10000024, 128'h01020304_05060708_0, 128'h0A0B0C0D_0E0F1011_0, 128'h0, 1);

    phase = "R3";
    send(good_insn(), '1, '1, '1, 1);
    send(good_insn(), '1, '1, 128'h0, 1);

    phase = "R4";
    for (int i = 0; i < 8; i++) begin
      a = rvec(); b = rvec();
      send(good_insn(), a, b, 128'h5, 1);
      a[63:0] = {$urandom, $urandom}; b[63:0] = {$urandom, $urandom};
      send(good_insn(), a, b, 128'h5, 1);
    end

    phase = "R6";
    for (int i = 0; i < 10; i++) begin
      logic [31:0] w;
      w = good_insn();
      if (i % 2 == 0) w[31:26] = 6'd5 + 6'(i); else w[5:0] = 6'd37 + 6'(i);
      send(w, rvec(), rvec(), rvec(), i % 3 != 0);
    end
    send(good_insn(), rvec(), rvec(), rvec(), 1);
    send({$urandom} & 32'h03FFFFC0, rvec(), rvec(), rvec(), 1);

    phase = "R7";
    for (int i = 0; i < 6; i++) send(good_insn(), rvec(), rvec(), rvec(), 0);
    send(good_insn(), rvec(), rvec(), rvec(), 1);
    send(good_insn(), rvec(), rvec(), rvec(), 0);

    phase = "R9";
    bp_mode = 1;
    for (int i = 0; i < 60; i++) send(i % 7 == 3 ? 32'h0 : good_insn(), rvec(), rvec(), rvec(), i % 9 != 4);
    bp_mode = 0;
    @(posedge clk); #1 out_ready = 1;

    phase = "R8";
    for (int i = 0; i < 10; i++) send(good_insn(), rvec(), rvec(), '1, 1);
    repeat (4) @(posedge clk);

    phase = "R1";
    #1 rst_n = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    repeat (3) @(posedge clk);
    finish_run();
  end
endmodule